// File: doc/BRIEF.md
# Wide-to-Narrow Random Word Buffer

This block sits between a random number generator core that produces 512-bit words and a consumer that takes 32-bit words one at a time. It stores a small number of wide entries in a circular buffer and presents the oldest entry as a stream of narrow words. The most significant 32-bit slice of an entry comes out first.

On the producer side, `want_more_o` is high whenever there is a free entry. A 512-bit word is captured on any clock edge where `wide_valid_i` is high and a slot is free, so a strobe of one cycle is enough. On the consumer side, `word_avail_o` is high while at least one entry is buffered. `word_o` holds its value until the consumer pulses `word_ack_i`. After the last slice of an entry is acknowledged, the entry is released and the next one is presented. `flush_i` drops everything that is buffered.

Top module: `rng_word_fifo`

## Requirements
- R1: After synchronous reset, `word_avail_o` is 0 and `want_more_o` is 1.
- R2: `want_more_o` is 1 exactly when fewer than DEPTH (default 4) entries are buffered. DEPTH writes in a row with no acknowledges fill the buffer and keep all entries.
- R3: A `wide_valid_i` strobe lasting one cycle stores the word when a slot is free. If the buffer was empty, `word_avail_o` rises on the next cycle.
- R4: The slices of an entry are presented most significant first. Slice n, counting from 0, is bits [511-32n : 480-32n].
- R5: While `word_avail_o` is 1 and no acknowledge or flush arrives, `word_o` and `word_avail_o` hold their values.
- R6: After the sixteenth acknowledge of an entry, the entry is released, a slot is freed, and the next stored entry (in write order) is presented from its top slice.
- R7: A `wide_valid_i` strobe while the buffer is full is ignored, and the buffered contents are unchanged.
- R8: `word_ack_i` while `word_avail_o` is 0 has no effect. A word written afterwards still starts with its top slice.
- R9: A write and an entry release in the same cycle leave the occupancy unchanged.
- R10: `flush_i` empties the buffer on the next cycle: `word_avail_o` becomes 0 and `want_more_o` becomes 1. A write in the same cycle is dropped, and the next entry starts with its top slice.
- R11: Entries keep their order across any number of wraps of the circular pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Drop all buffered entries |
| wide_data_i | input | IN_W (512) | Wide word from the generator |
| wide_valid_i | input | 1 | Wide word is valid this cycle |
| want_more_o | output | 1 | A free entry exists |
| word_o | output | OUT_W (32) | Current narrow word |
| word_avail_o | output | 1 | `word_o` holds valid data |
| word_ack_i | input | 1 | Consumer has taken `word_o` |

## Verification
The assertions check the following on every cycle:
- the reset and flush outcomes;
- that the output word and its flag hold while no acknowledge arrives;
- that a full buffer stays full without an acknowledge;
- that a write into an empty buffer presents that word's top slice next;
- that the occupancy never exceeds the depth.

Some properties need an end-to-end view and only the bench scenarios can show them:
- the full most-significant-first order across sixteen acknowledges;
- write order across pointer wraps;
- that a write into a full buffer, or an acknowledge into an empty one, leaves no trace;
- that a write and a release in the same cycle keep the count.

// File: rtl/rngw_pkg.sv
package rngw_pkg;

    // Per-cycle control decisions shared by the controller and top level.
    typedef struct packed {
        logic clear;   // flush: reset all pointers and the count
        logic push;    // wide word accepted into the write slot
        logic adv;     // acknowledge taken on a valid narrow word
        logic retire;  // acknowledge of the last slice of an entry
    } fifo_op_t;

    // Bit offset of narrow lane 'lane' when lane 0 is the top slice.
    function automatic int lane_base(input int lane, input int lanes, input int w);
        return (lanes - 1 - lane) * w;
    endfunction

endpackage

// File: rtl/rngw_ctrl.sv
module rngw_ctrl
    import rngw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LANES = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             valid,
    input  logic             ack,
    output fifo_op_t         op,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] occ
);

    logic full, have;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (occ == CNT_W'(DEPTH));
        have      = (occ != '0);
        op.clear  = flush;
        op.push   = valid && !full && !flush;
        op.adv    = ack && have && !flush;
        op.retire = op.adv && (sel == SEL_W'(LANES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || op.clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            sel    <= '0;
            occ    <= '0;
        end else begin
            if (op.push)
                wr_ptr <= bump(wr_ptr);
            if (op.retire) begin
                rd_ptr <= bump(rd_ptr);
                sel    <= '0;
            end else if (op.adv) begin
                sel <= sel + 1'b1;
            end
            case ({op.push, op.retire})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/rngw_store.sv
module rngw_store #(
    parameter int DEPTH = 4,
    parameter int IN_W  = 512,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [IN_W-1:0]  wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [IN_W-1:0]  rdata
);

    logic [IN_W-1:0] slots [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == PTR_W'(e)))
                slots[e] <= wdata;
        end
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/rngw_lane_sel.sv
module rngw_lane_sel
    import rngw_pkg::*;
#(
    parameter int IN_W  = 512,
    parameter int OUT_W = 32,
    localparam int LANES = IN_W / OUT_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [IN_W-1:0]  entry,
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_W-1:0] word
);

    logic [OUT_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BASE = lane_base(g, LANES, OUT_W);
        assign lanes[g] = entry[BASE +: OUT_W];
    end

    assign word = lanes[sel];

endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo
    import rngw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IN_W  = 512,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [IN_W-1:0]  wide_data_i,
    input  logic             wide_valid_i,
    output logic             want_more_o,
    output logic [OUT_W-1:0] word_o,
    output logic             word_avail_o,
    input  logic             word_ack_i
);

    localparam int LANES = IN_W / OUT_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    fifo_op_t         op;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] occ;
    logic [IN_W-1:0]  head;

    rngw_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush_i),
        .valid  (wide_valid_i),
        .ack    (word_ack_i),
        .op     (op),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .sel    (sel),
        .occ    (occ)
    );

    rngw_store #(.DEPTH(DEPTH), .IN_W(IN_W)) u_store (
        .clk   (clk),
        .we    (op.push),
        .waddr (wr_ptr),
        .wdata (wide_data_i),
        .raddr (rd_ptr),
        .rdata (head)
    );

    rngw_lane_sel #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sel (
        .entry (head),
        .sel   (sel),
        .word  (word_o)
    );

    assign want_more_o  = (occ < CNT_W'(DEPTH));
    assign word_avail_o = (occ != '0);

endmodule

// File: rtl/rngw_chk.sv
module rngw_chk #(
    parameter int DEPTH = 4,
    parameter int IN_W  = 512,
    parameter int OUT_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic [IN_W-1:0]  wide_data_i,
    input logic             wide_valid_i,
    input logic             want_more_o,
    input logic [OUT_W-1:0] word_o,
    input logic             word_avail_o,
    input logic             word_ack_i,
    input logic [CNT_W-1:0] occ
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!word_avail_o && want_more_o));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!word_avail_o && want_more_o));

    // R5
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (word_avail_o && !word_ack_i && !flush_i) |=> (word_avail_o && $stable(word_o)));

    // R2
    full_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!want_more_o && !word_ack_i && !flush_i) |=> !want_more_o);

    // R3
    first_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_avail_o && wide_valid_i && !flush_i)
        |=> (word_avail_o && word_o == $past(wide_data_i[IN_W-1 -: OUT_W])));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

endmodule

bind rng_word_fifo rngw_chk #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .wide_data_i  (wide_data_i),
    .wide_valid_i (wide_valid_i),
    .want_more_o  (want_more_o),
    .word_o       (word_o),
    .word_avail_o (word_avail_o),
    .word_ack_i   (word_ack_i),
    .occ          (occ)
);

// File: tb/tb_rng_word_fifo.sv
module tb_rng_word_fifo;

    localparam int DEPTH = 4;
    localparam int IN_W  = 512;
    localparam int OUT_W = 32;
    localparam int LANES = IN_W / OUT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush_i = 1'b0;
    logic [IN_W-1:0]  wide_data_i = '0;
    logic             wide_valid_i = 1'b0;
    logic             want_more_o;
    logic [OUT_W-1:0] word_o;
    logic             word_avail_o;
    logic             word_ack_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rng_word_fifo #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (flush_i),
        .wide_data_i  (wide_data_i),
        .wide_valid_i (wide_valid_i),
        .want_more_o  (want_more_o),
        .word_o       (word_o),
        .word_avail_o (word_avail_o),
        .word_ack_i   (word_ack_i)
    );

    function automatic logic [OUT_W-1:0] mk(input int k, input int s);
        return OUT_W'((k * 32'h0100_0193) ^ (s * 32'h9E37_79B9) ^ (s << 4) ^ 32'h5A5A_0000);
    endfunction

    function automatic logic [IN_W-1:0] build(input int k);
        logic [IN_W-1:0] w;
        for (int s = 0; s < LANES; s++) w[s*OUT_W +: OUT_W] = mk(k, s);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [OUT_W-1:0] act,
                         input logic [OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int k);
        wide_data_i  = build(k);
        wide_valid_i = 1'b1;
        @(negedge clk);
        wide_valid_i = 1'b0;
    endtask

    // Check narrow word i of entry k, then acknowledge it (optionally with a write).
    task automatic pop(input int k, input int i, input string req,
                       input bit with_push = 1'b0, input int pk = 0);
        logic [OUT_W-1:0] e;
        e = mk(k, LANES - 1 - i);
        check(word_avail_o == 1'b1, req, OUT_W'(word_avail_o), 1);
        check(word_o == e, req, word_o, e);
        if (with_push) begin
            wide_data_i  = build(pk);
            wide_valid_i = 1'b1;
        end
        word_ack_i = 1'b1;
        @(negedge clk);
        word_ack_i   = 1'b0;
        wide_valid_i = 1'b0;
    endtask

    task automatic drain(input int k, input string req);
        for (int i = 0; i < LANES; i++) pop(k, i, req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check(word_avail_o == 1'b0, "R1", OUT_W'(word_avail_o), 0);
        check(want_more_o == 1'b1, "R1", OUT_W'(want_more_o), 1);

        // R2 / R3: four back-to-back single-cycle writes are all kept
        for (int k = 1; k <= DEPTH; k++) begin
            push(k);
            check(want_more_o == (k < DEPTH), "R2", OUT_W'(want_more_o), OUT_W'(k < DEPTH));
        end
        // R7: write into a full buffer is ignored
        push(99);
        check(want_more_o == 1'b0, "R7", OUT_W'(want_more_o), 0);
        // R4 / R6: every entry comes out top slice first, in write order
        drain(1, "R4");
        check(want_more_o == 1'b1, "R6", OUT_W'(want_more_o), 1);
        drain(2, "R6");
        drain(3, "R6");
        drain(4, "R7");
        check(word_avail_o == 1'b0, "R7", OUT_W'(word_avail_o), 0);

        // R8: acknowledges on an empty buffer do nothing
        word_ack_i = 1'b1;
        repeat (3) @(negedge clk);
        word_ack_i = 1'b0;
        check(word_avail_o == 1'b0, "R8", OUT_W'(word_avail_o), 0);
        push(5);
        drain(5, "R8");
        check(word_avail_o == 1'b0, "R8", OUT_W'(word_avail_o), 0);

        // R9: write and release in the same cycle
        push(6); push(7); push(8);
        for (int i = 0; i < LANES - 1; i++) pop(6, i, "R9");
        pop(6, LANES - 1, "R9", 1'b1, 9);
        check(want_more_o == 1'b1, "R9", OUT_W'(want_more_o), 1);
        push(10);
        check(want_more_o == 1'b0, "R9", OUT_W'(want_more_o), 0);
        // R11: order kept after the pointers have wrapped
        drain(7, "R11"); drain(8, "R11"); drain(9, "R11"); drain(10, "R11");
        check(word_avail_o == 1'b0, "R11", OUT_W'(word_avail_o), 0);

        // R10: flush mid-entry, with a write in the same cycle
        push(11); push(12);
        for (int i = 0; i < 3; i++) pop(11, i, "R10");
        wide_data_i  = build(13);
        wide_valid_i = 1'b1;
        flush_i      = 1'b1;
        @(negedge clk);
        wide_valid_i = 1'b0;
        flush_i      = 1'b0;
        check(word_avail_o == 1'b0, "R10", OUT_W'(word_avail_o), 0);
        check(want_more_o == 1'b1, "R10", OUT_W'(want_more_o), 1);
        push(14);
        drain(14, "R10");
        check(word_avail_o == 1'b0, "R10", OUT_W'(word_avail_o), 0);

        // R5: word holds while no acknowledge arrives
        push(15);
        repeat (5) begin
            @(negedge clk);
            check(word_o == mk(15, LANES - 1), "R5", word_o, mk(15, LANES - 1));
        end
        drain(15, "R5");

        // R11: sweep of pairs through many pointer wraps
        for (int r = 0; r < 8; r++) begin
            push(100 + 2 * r);
            push(101 + 2 * r);
            drain(100 + 2 * r, "R11");
            drain(101 + 2 * r, "R11");
            check(word_avail_o == 1'b0, "R11", OUT_W'(word_avail_o), 0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule